// File: doc/BRIEF.md
# PC-Relative Register-Pair Load Sequencer

This block carries out one PC-relative load of two 32-bit words into a pair of destination registers. It takes a request that has already been decoded. The request carries a condition-pass flag, the current PC, a selector for the encoding form, the raw immediate fields, an up/down bit, the destination register numbers, a writeback bit and an endianness flag. From these the block builds the byte offset and the literal address. It then fetches the data over a simple valid/ready memory port and presents both register writes together for one cycle.

The base is the PC rounded down to a word boundary. When the final address is a multiple of 8, the block issues one 64-bit read and steers its halves to the two registers according to endianness. Any other address produces two 32-bit reads, one after the other. The block also checks the destination-register encoding. It raises a flag for combinations that have no defined outcome, but it still performs the load.

A request is taken only while `req_ready` is high, which is true only when the sequencer is idle. A request whose condition-pass flag is low is taken and dropped without any side effect.

Top module: `pcrel_pair_loader`

## Requirements
- R1: The address is the PC with bits [1:0] forced to zero, plus the offset when `req_up` is 1 or minus it when `req_up` is 0, computed modulo 2^32.
- R2: With `req_enc_mixed` = 0, the offset is `{req_imm_hi, req_imm_lo}` zero-extended (0 to 255, byte granular).
- R3: With `req_enc_mixed` = 1, the offset is `req_imm8` times 4 zero-extended (0 to 1020).
- R4: With `req_enc_mixed` = 0, `wr_idx0` = `req_rt` and `wr_idx1` = `req_rt`+1 modulo 16; `wr_unpred` is 1 exactly when `req_rt` is odd or `req_rt` is 14.
- R5: With `req_enc_mixed` = 1, `wr_idx0` = `req_rt` and `wr_idx1` = `req_rt2`; `wr_unpred` is 1 exactly when either number is 15, when they are equal, or when `req_wback` is 1.
- R6: An address whose bits [2:0] are zero produces exactly one read with `mem_wide` = 1 at that address. Address and width stay stable while `mem_valid` waits for `mem_ready`.
- R7: Any other address produces exactly two reads with `mem_wide` = 0, first at the address and then at address+4. Each read takes its word from `mem_rdata[31:0]`. The first word goes to `wr_data0` and the second to `wr_data1`.
- R8: For a 64-bit read with `req_big_endian` = 0, `wr_data0` = `mem_rdata[31:0]` and `wr_data1` = `mem_rdata[63:32]`. With `req_big_endian` = 1 the two are swapped.
- R9: A request taken with `req_cond_pass` = 0 causes no memory read and no `done`.
- R10: `done` is high for exactly one cycle, in the cycle right after the last memory handshake. `req_ready` is high only while no load is in flight.
- R11: A request flagged unpredictable still performs its reads and register writes using the computed register numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_cond_pass | input | 1 | Condition passed; 0 drops the request |
| req_pc | input | 32 | Current PC |
| req_enc_mixed | input | 1 | 0: fixed-width form, 1: mixed-width form |
| req_imm_hi | input | 4 | Upper offset nibble (fixed-width form) |
| req_imm_lo | input | 4 | Lower offset nibble (fixed-width form) |
| req_imm8 | input | 8 | Word-scaled offset field (mixed-width form) |
| req_up | input | 1 | 1: add offset, 0: subtract |
| req_rt | input | 4 | First destination register number |
| req_rt2 | input | 4 | Second destination register number (mixed-width form) |
| req_wback | input | 1 | Writeback bit (mixed-width form) |
| req_big_endian | input | 1 | 1: big-endian lane order for a 64-bit read |
| mem_valid | output | 1 | Read request valid |
| mem_ready | input | 1 | Memory accepts the read; data valid in the same cycle |
| mem_addr | output | 32 | Read byte address |
| mem_wide | output | 1 | 1: 64-bit read, 0: 32-bit read |
| mem_rdata | input | 64 | Read data; 32-bit reads use bits [31:0] |
| done | output | 1 | Both register writes valid this cycle |
| wr_idx0 | output | 4 | First register number |
| wr_data0 | output | 32 | First register data |
| wr_idx1 | output | 4 | Second register number |
| wr_data1 | output | 32 | Second register data |
| wr_unpred | output | 1 | Encoding flagged unpredictable |

## Verification
The first read appears one cycle after the accepting edge. Each read completes on the edge where `mem_ready` meets `mem_valid`. `done` follows exactly one cycle after the last completed read, so an aligned request with an immediately ready memory finishes in two cycles and a split request in three. Because the memory stalls at random, the bench logs the cycle of every handshake away from the clock edge. It then requires `done` in the next cycle and its absence one cycle later, rather than expecting a fixed latency. Addresses, widths, register numbers, data and the unpredictable flag are compared against bench functions driven from the request fields.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int RIDX_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ64,
        ST_REQ_LO,
        ST_REQ_HI,
        ST_WRITE
    } seq_state_e;

    typedef struct packed {
        seq_state_e          state;
        logic [ADDR_W-1:0]   addr;
        logic [RIDX_W-1:0]   idx0;
        logic [RIDX_W-1:0]   idx1;
        logic                big;
        logic                unpred;
        logic [WORD_W-1:0]   data0;
        logic [WORD_W-1:0]   data1;
    } seq_regs_t;
endpackage

// File: rtl/pcrel_addr_gen.sv
module pcrel_addr_gen #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc,
    input  logic          mixed,
    input  logic [3:0]    imm_hi,
    input  logic [3:0]    imm_lo,
    input  logic [7:0]    imm8,
    input  logic          up,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] base;
    logic [AW-1:0] offset;

    always_comb begin
        base   = {pc[AW-1:2], 2'b00};
        offset = mixed ? AW'({imm8, 2'b00}) : AW'({imm_hi, imm_lo});
        addr   = up ? (base + offset) : (base - offset);
    end
endmodule

// File: rtl/pcrel_reg_check.sv
module pcrel_reg_check #(
    parameter int RW = 4
) (
    input  logic          mixed,
    input  logic [RW-1:0] rt,
    input  logic [RW-1:0] rt2,
    input  logic          wback,
    output logic [RW-1:0] idx0,
    output logic [RW-1:0] idx1,
    output logic          unpred
);
    localparam logic [RW-1:0] PC_IDX = '1;

    always_comb begin
        idx0 = rt;
        if (mixed) begin
            idx1   = rt2;
            unpred = (rt == PC_IDX) || (rt2 == PC_IDX) || (rt == rt2) || wback;
        end else begin
            idx1   = rt + RW'(1);
            unpred = rt[0] || (idx1 == PC_IDX);
        end
    end
endmodule

// File: rtl/pcrel_pair_loader.sv
module pcrel_pair_loader
    import pcrel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_cond_pass,
    input  logic [ADDR_W-1:0]   req_pc,
    input  logic                req_enc_mixed,
    input  logic [3:0]          req_imm_hi,
    input  logic [3:0]          req_imm_lo,
    input  logic [7:0]          req_imm8,
    input  logic                req_up,
    input  logic [RIDX_W-1:0]   req_rt,
    input  logic [RIDX_W-1:0]   req_rt2,
    input  logic                req_wback,
    input  logic                req_big_endian,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_wide,
    input  logic [2*WORD_W-1:0] mem_rdata,
    output logic                done,
    output logic [RIDX_W-1:0]   wr_idx0,
    output logic [WORD_W-1:0]   wr_data0,
    output logic [RIDX_W-1:0]   wr_idx1,
    output logic [WORD_W-1:0]   wr_data1,
    output logic                wr_unpred
);
    localparam int DW_BYTES = (2 * WORD_W) / 8;
    localparam int WD_BYTES = WORD_W / 8;
    localparam int ALN_BITS = $clog2(DW_BYTES);

    seq_regs_t r_d, r_q;

    logic [ADDR_W-1:0] calc_addr;
    logic [RIDX_W-1:0] calc_idx0, calc_idx1;
    logic              calc_unpred;

    pcrel_addr_gen #(.AW(ADDR_W)) u_addr (
        .pc     (req_pc),
        .mixed  (req_enc_mixed),
        .imm_hi (req_imm_hi),
        .imm_lo (req_imm_lo),
        .imm8   (req_imm8),
        .up     (req_up),
        .addr   (calc_addr)
    );

    pcrel_reg_check #(.RW(RIDX_W)) u_regs (
        .mixed  (req_enc_mixed),
        .rt     (req_rt),
        .rt2    (req_rt2),
        .wback  (req_wback),
        .idx0   (calc_idx0),
        .idx1   (calc_idx1),
        .unpred (calc_unpred)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid && req_cond_pass) begin
                    r_d.addr   = calc_addr;
                    r_d.idx0   = calc_idx0;
                    r_d.idx1   = calc_idx1;
                    r_d.unpred = calc_unpred;
                    r_d.big    = req_big_endian;
                    r_d.state  = (calc_addr[ALN_BITS-1:0] == '0) ? ST_REQ64 : ST_REQ_LO;
                end
            end
            ST_REQ64: begin
                if (mem_ready) begin
                    r_d.data0 = r_q.big ? mem_rdata[2*WORD_W-1:WORD_W] : mem_rdata[WORD_W-1:0];
                    r_d.data1 = r_q.big ? mem_rdata[WORD_W-1:0] : mem_rdata[2*WORD_W-1:WORD_W];
                    r_d.state = ST_WRITE;
                end
            end
            ST_REQ_LO: begin
                if (mem_ready) begin
                    r_d.data0 = mem_rdata[WORD_W-1:0];
                    r_d.state = ST_REQ_HI;
                end
            end
            ST_REQ_HI: begin
                if (mem_ready) begin
                    r_d.data1 = mem_rdata[WORD_W-1:0];
                    r_d.state = ST_WRITE;
                end
            end
            ST_WRITE: r_d.state = ST_IDLE;
            default:  r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready = (r_q.state == ST_IDLE);
        mem_valid = (r_q.state == ST_REQ64) || (r_q.state == ST_REQ_LO) || (r_q.state == ST_REQ_HI);
        mem_wide  = (r_q.state == ST_REQ64);
        mem_addr  = (r_q.state == ST_REQ_HI) ? (r_q.addr + ADDR_W'(WD_BYTES)) : r_q.addr;
        done      = (r_q.state == ST_WRITE);
        wr_idx0   = r_q.idx0;
        wr_idx1   = r_q.idx1;
        wr_data0  = r_q.data0;
        wr_data1  = r_q.data1;
        wr_unpred = r_q.unpred;
    end

    AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_wide) |-> (mem_addr[ALN_BITS-1:0] == '0)) else $error("wide read misaligned"); // R6
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wide))) else $error("read dropped or changed"); // R6
    AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_wide && r_q.state == ST_REQ_LO)
        |=> (mem_valid && !mem_wide && mem_addr == $past(mem_addr) + ADDR_W'(WD_BYTES))) else $error("second word address"); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R10
    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_valid && mem_ready)) else $error("done without read"); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_valid && !done)) else $error("activity while idle"); // R10
    AST_DROP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !req_cond_pass) |=> req_ready) else $error("dropped request started"); // R9
endmodule

// File: tb/pcrel_pair_loader_bench.sv
`timescale 1ns/1ps
module pcrel_pair_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_cond_pass = 1'b0;
    logic [31:0] req_pc = '0;
    logic        req_enc_mixed = 1'b0;
    logic [3:0]  req_imm_hi = '0, req_imm_lo = '0;
    logic [7:0]  req_imm8 = '0;
    logic        req_up = 1'b0;
    logic [3:0]  req_rt = '0, req_rt2 = '0;
    logic        req_wback = 1'b0, req_big_endian = 1'b0;
    logic        mem_valid, mem_ready = 1'b0, mem_wide;
    logic [31:0] mem_addr;
    logic [63:0] mem_rdata;
    logic        done, wr_unpred;
    logic [3:0]  wr_idx0, wr_idx1;
    logic [31:0] wr_data0, wr_data1;

    int total = 0, bad = 0, cyc = 0, hs_n = 0, last_hs = 0;
    logic [31:0] hs_addr [2];
    logic        hs_wide [2];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] mw(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A17_C3E9;
    endfunction

    assign mem_rdata = mem_wide ? {mw(mem_addr + 32'd4), mw(mem_addr)} : {32'hDEAD_BEEF, mw(mem_addr)};

    pcrel_pair_loader u_pcrel_pair_loader (.*);

    always @(negedge clk) begin
        mem_ready = rst_n && ($urandom % 4 != 0);
        #1;
        cyc++;
        if (rst_n && mem_valid && mem_ready) begin
            if (hs_n < 2) begin
                hs_addr[hs_n] = mem_addr;
                hs_wide[hs_n] = mem_wide;
            end
            hs_n++;
            last_hs = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] pc, input bit mixed,
        input logic [3:0] hi, input logic [3:0] lo, input logic [7:0] i8, input bit up);
        logic [31:0] off;
        off = mixed ? {22'd0, i8, 2'b00} : {24'd0, hi, lo};
        return up ? ((pc & ~32'd3) + off) : ((pc & ~32'd3) - off);
    endfunction

    task automatic run_req(input bit cond, input logic [31:0] pc, input bit mixed,
        input logic [3:0] hi, input logic [3:0] lo, input logic [7:0] i8, input bit up,
        input logic [3:0] rt, input logic [3:0] rt2, input bit wb, input bit big);
        logic [31:0] a;
        logic [3:0]  e1;
        bit          eu, aligned, seen;
        int          dcyc;
        a = exp_addr(pc, mixed, hi, lo, i8, up);
        aligned = (a[2:0] == 3'd0);
        if (mixed) begin
            e1 = rt2;
            eu = (rt == 4'd15) || (rt2 == 4'd15) || (rt == rt2) || wb;
        end else begin
            e1 = rt + 4'd1;
            eu = rt[0] || (rt == 4'd14);
        end
        @(negedge clk); #2;
        req_valid = 1'b1; req_cond_pass = cond; req_pc = pc; req_enc_mixed = mixed;
        req_imm_hi = hi; req_imm_lo = lo; req_imm8 = i8; req_up = up;
        req_rt = rt; req_rt2 = rt2; req_wback = wb; req_big_endian = big;
        hs_n = 0;
        chk(req_ready == 1'b1, "R10 ready when idle", 64'(req_ready), 64'd1);
        @(negedge clk); #2;
        req_valid = 1'b0;
        seen = 1'b0; dcyc = 0;
        for (int i = 0; i < 60; i++) begin
            if (done) begin seen = 1'b1; dcyc = cyc; break; end
            if (!cond && i == 6) break;
            @(negedge clk); #2;
        end
        if (!cond) begin
            chk(!seen, "R9 no done when condition fails", 64'(seen), 64'd0);
            chk(hs_n == 0, "R9 no read when condition fails", 64'(hs_n), 64'd0);
            chk(req_ready == 1'b1, "R9 stays idle", 64'(req_ready), 64'd1);
            return;
        end
        chk(seen, "R10 done arrives", 64'(seen), 64'd1);
        if (!seen) return;
        chk(dcyc == last_hs + 1, "R10 done one cycle after last read", 64'(dcyc), 64'(last_hs + 1));
        chk(hs_n == (aligned ? 1 : 2), aligned ? "R6 single wide read" : "R7 two word reads",
            64'(hs_n), 64'(aligned ? 1 : 2));
        chk(hs_addr[0] == a, "R1 R2 R3 read address", 64'(hs_addr[0]), 64'(a));
        chk(hs_wide[0] == aligned, aligned ? "R6 read width" : "R7 read width", 64'(hs_wide[0]), 64'(aligned));
        if (!aligned && hs_n == 2) begin
            chk(hs_addr[1] == a + 32'd4 && !hs_wide[1], "R7 second read at address+4",
                64'(hs_addr[1]), 64'(a + 32'd4));
        end
        chk(wr_idx0 == rt, mixed ? "R5 first index" : "R4 first index", 64'(wr_idx0), 64'(rt));
        chk(wr_idx1 == e1, mixed ? "R5 second index" : "R4 second index", 64'(wr_idx1), 64'(e1));
        chk(wr_unpred == eu, mixed ? "R5 unpredictable flag" : "R4 unpredictable flag", 64'(wr_unpred), 64'(eu));
        chk(wr_data0 == ((aligned && big) ? mw(a + 32'd4) : mw(a)),
            aligned ? "R8 first data lane" : "R7 first data", 64'(wr_data0),
            64'((aligned && big) ? mw(a + 32'd4) : mw(a)));
        chk(wr_data1 == ((aligned && big) ? mw(a) : mw(a + 32'd4)),
            aligned ? "R8 second data lane" : "R7 second data", 64'(wr_data1),
            64'((aligned && big) ? mw(a) : mw(a + 32'd4)));
        if (eu) chk(1'b1, "R11 flagged request executed", 64'd1, 64'd1);
        @(negedge clk); #2;
        chk(!done && req_ready, "R10 done single cycle", 64'({done, req_ready}), 64'b01);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(req_ready && !mem_valid && !done, "R10 reset state", 64'({req_ready, mem_valid, done}), 64'b100);
        // directed corner cases
        run_req(1, 32'h0000_1003, 0, 4'h0, 4'h8, 8'h00, 1, 4'd2, 4'd0, 0, 0);   // R1 R2 R6 aligned LE
        run_req(1, 32'h0000_1000, 0, 4'h0, 4'h8, 8'h00, 1, 4'd4, 4'd0, 0, 1);   // R8 aligned BE
        run_req(1, 32'h0000_1000, 0, 4'hF, 4'hF, 8'h00, 1, 4'd0, 4'd0, 0, 1);   // R7 odd byte address
        run_req(1, 32'h0000_0002, 1, 4'h0, 4'h0, 8'h01, 0, 4'd1, 4'd3, 0, 0);   // R1 R3 wrap below zero
        run_req(1, 32'hFFFF_FFFE, 1, 4'h0, 4'h0, 8'hFF, 1, 4'd5, 4'd6, 0, 1);   // R1 R3 wrap above top
        run_req(1, 32'h0000_2000, 0, 4'h0, 4'h0, 8'h00, 1, 4'd14, 4'd0, 0, 0);  // R4 R11 second is 15
        run_req(1, 32'h0000_2000, 0, 4'h0, 4'h4, 8'h00, 1, 4'd3, 4'd0, 0, 0);   // R4 R11 odd first
        run_req(1, 32'h0000_2000, 1, 4'h0, 4'h0, 8'h02, 1, 4'd7, 4'd7, 0, 0);   // R5 equal pair
        run_req(1, 32'h0000_2000, 1, 4'h0, 4'h0, 8'h03, 1, 4'd2, 4'd9, 1, 1);   // R5 writeback set
        run_req(1, 32'h0000_2000, 1, 4'h0, 4'h0, 8'h03, 1, 4'd15, 4'd9, 0, 0);  // R5 first is 15
        run_req(0, 32'h0000_3000, 0, 4'h1, 4'h0, 8'h00, 1, 4'd0, 4'd0, 0, 0);   // R9 dropped
        for (int n = 0; n < 400; n++) begin
            run_req(($urandom % 8) != 0, $urandom, $urandom % 2, 4'($urandom), 4'($urandom),
                8'($urandom), $urandom % 2, 4'($urandom), 4'($urandom),
                ($urandom % 6) == 0, $urandom % 2);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule